// File: doc/BRIEF.md
# Composite Clock Root Slice

This block produces one clock root from a set of parent clocks. A single 32-bit control word picks the parent, sets two integer dividers in series and gates the result. The first divider is 3 bits wide and the second is 6 bits wide. Software changes any field with a read-modify-write of that word. Only the defined fields are stored, and every other bit reads as zero.

The whole slice runs on one fast system clock `clk`. The parent clocks are sampled through two-flop synchronizers. Each divider stage counts rising edges of its input. A divided output is high for floor(N/2) of its input periods and low for the rest. A ratio of 1 passes the sampled parent straight through. A new configuration is held back until the running output period completes, so switching never shortens a phase.

The control state machine has three states. OFF holds the output low and tracks the register continuously. RUN drives the divided clock. PEND drives the divided clock while a new configuration waits. The transitions are:
- OFF to RUN when the enable bit is set.
- RUN to PEND when the requested configuration differs from the effective one.
- PEND to RUN at the period boundary, where the new configuration is loaded.
- Any state to OFF when the enable bit is cleared.

A period boundary is the parent rising edge on which both divider counters wrap.

Top module: `clk_root_slice`

## Requirements
- R1: Control word layout: enable at bit 28, parent select at bits 26:24, pre-divider field at bits 18:16, post-divider field at bits 5:0. After a write, the register reads back the written value ANDed with 0x1707003F. All other bits read as zero.
- R2: The pre-divide ratio is the pre-divider field plus one, covering 1 to 8.
- R3: The post-divide ratio is the post-divider field plus one, covering 1 to 64.
- R4: With parent i selected, the output period is the parent period times the pre-divide ratio times the post-divide ratio.
- R5: High time of the output, with P the parent period, A the pre-divide ratio and B the post-divide ratio:
  - floor(B/2)·A·P when B ≥ 2;
  - floor(A/2)·P when B = 1 and A ≥ 2;
  - the parent's own high time when A = B = 1.
- R6: While the enable bit is 0 the output is held low, starting one clock after the enable bit reads 0.
- R7: A parent select value at or above the number of parents (6 by default) raises `sel_err`. The output then keeps running from the last valid parent.
- R8: A change to the select or divider fields takes effect only at the next period boundary. The period in progress completes unchanged.
- R9: `pre_ratio` and `post_ratio` report the effective ratios (field plus one). They change only when a configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Writes `wr_data` into the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| par_clk | input | NPAR | Parent clocks |
| root_clk | output | 1 | Gated, selected and divided clock root |
| sel_err | output | 1 | Stored parent select is out of range |
| pre_ratio | output | PRE_W+1 | Effective pre-divide ratio |
| post_ratio | output | POST_W+1 | Effective post-divide ratio |

## Verification
The bench sweeps the pre-divider over all eight values with post ratios 1 to 3, and the post-divider over all 64 values at pre ratio 1. Measuring period and high time separately tells the two stages apart and exposes wrong odd-ratio duty and broken pass-through. Every parent is selected in turn at one fixed ratio, each with its own parent period, so a wrong mux index shows up as a wrong period. Separate runs cover three further cases:
- A switch from the largest ratio to ratio 1 taken mid-period, which shows whether the old period is cut short.
- An out-of-range select while running.
- Clearing the enable bit.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;

    localparam int CTRL_W   = 32;
    localparam int EN_BIT   = 28;
    localparam int SEL_LSB  = 24;
    localparam int SEL_W    = 3;
    localparam int PRE_LSB  = 16;
    localparam int PRE_W    = 3;
    localparam int POST_LSB = 0;
    localparam int POST_W   = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } root_state_e;

    function automatic logic [CTRL_W-1:0] ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[EN_BIT] = 1'b1;
        m[SEL_LSB +: SEL_W] = '1;
        m[PRE_LSB +: PRE_W] = '1;
        m[POST_LSB +: POST_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/clk_root_regs.sv
module clk_root_regs
    import clk_root_pkg::*;
#(
    parameter int NPAR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              en,
    output logic [SEL_W-1:0]  sel,
    output logic              sel_ok,
    output logic [PRE_W-1:0]  pre,
    output logic [POST_W-1:0] post
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            sel  <= '0;
            pre  <= '0;
            post <= '0;
        end else if (wr_en) begin
            en   <= wr_data[EN_BIT];
            sel  <= wr_data[SEL_LSB +: SEL_W];
            pre  <= wr_data[PRE_LSB +: PRE_W];
            post <= wr_data[POST_LSB +: POST_W];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[EN_BIT] = en;
        rd_data[SEL_LSB +: SEL_W] = sel;
        rd_data[PRE_LSB +: PRE_W] = pre;
        rd_data[POST_LSB +: POST_W] = post;
    end

    assign sel_ok = (32'(sel) < NPAR);

endmodule

// File: rtl/clk_root_sync.sv
module clk_root_sync #(
    parameter int NPAR = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPAR-1:0] par_clk,
    output logic [NPAR-1:0] par_sync
);

    for (genvar g = 0; g < NPAR; g++) begin : g_sync
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= par_clk[g];
                sync_q <= meta_q;
            end
        end

        assign par_sync[g] = sync_q;
    end

endmodule

// File: rtl/clk_root_div.sv
module clk_root_div
    import clk_root_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic              req_sel_ok,
    input  logic [PRE_W-1:0]  req_pre,
    input  logic [POST_W-1:0] req_post,
    input  logic              src_lvl,
    output logic [SEL_W-1:0]  eff_sel,
    output logic [PRE_W-1:0]  eff_pre,
    output logic [POST_W-1:0] eff_post,
    output logic [PRE_W-1:0]  cnt_pre,
    output logic [POST_W-1:0] cnt_post,
    output logic              bnd,
    output root_state_e       state,
    output logic              root_clk
);

    root_state_e       state_n;
    logic              src_prev;
    logic              rise;
    logic              wrap_pre;
    logic              wrap_post;
    logic              pending;
    logic              load;
    logic [SEL_W-1:0]  want_sel;
    logic [SEL_W-1:0]  eff_sel_n;
    logic [PRE_W-1:0]  eff_pre_n;
    logic [POST_W-1:0] eff_post_n;
    logic [PRE_W-1:0]  cnt_pre_n;
    logic [POST_W-1:0] cnt_post_n;
    logic [PRE_W:0]    half_pre;
    logic [POST_W:0]   half_post;
    logic              root_n;

    assign rise      = src_lvl & ~src_prev;
    assign wrap_pre  = (cnt_pre == eff_pre);
    assign wrap_post = (cnt_post == eff_post);
    assign bnd       = (state != ST_OFF) && rise && wrap_pre && wrap_post;
    assign want_sel  = req_sel_ok ? req_sel : eff_sel;
    assign pending   = (want_sel != eff_sel) || (req_pre != eff_pre) ||
                       (req_post != eff_post);
    assign load      = (state == ST_OFF) || bnd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:  state_n = en ? ST_RUN : ST_OFF;
            ST_RUN: begin
                if (!en)                 state_n = ST_OFF;
                else if (pending && !bnd) state_n = ST_PEND;
                else                     state_n = ST_RUN;
            end
            ST_PEND: begin
                if (!en)      state_n = ST_OFF;
                else if (bnd) state_n = ST_RUN;
                else          state_n = ST_PEND;
            end
            default: state_n = ST_OFF;
        endcase
    end

    // configuration and counters
    always_comb begin
        eff_sel_n  = load ? want_sel : eff_sel;
        eff_pre_n  = load ? req_pre  : eff_pre;
        eff_post_n = load ? req_post : eff_post;
        cnt_pre_n  = cnt_pre;
        cnt_post_n = cnt_post;
        if (state == ST_OFF) begin
            cnt_pre_n  = req_pre;
            cnt_post_n = req_post;
        end else if (bnd) begin
            cnt_pre_n  = '0;
            cnt_post_n = '0;
        end else if (rise) begin
            if (wrap_pre) begin
                cnt_pre_n  = '0;
                cnt_post_n = POST_W'(cnt_post + 1'b1);
            end else begin
                cnt_pre_n  = PRE_W'(cnt_pre + 1'b1);
            end
        end
    end

    // outputs
    always_comb begin
        half_pre  = ({1'b0, eff_pre_n} + (PRE_W+1)'(1)) >> 1;
        half_post = ({1'b0, eff_post_n} + (POST_W+1)'(1)) >> 1;
        if (state == ST_OFF || !en)
            root_n = 1'b0;
        else if (eff_post_n != '0)
            root_n = ({1'b0, cnt_post_n} < half_post);
        else if (eff_pre_n != '0)
            root_n = ({1'b0, cnt_pre_n} < half_pre);
        else
            root_n = src_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_sel  <= '0;
            eff_pre  <= '0;
            eff_post <= '0;
            cnt_pre  <= '0;
            cnt_post <= '0;
            src_prev <= 1'b0;
            root_clk <= 1'b0;
        end else begin
            eff_sel  <= eff_sel_n;
            eff_pre  <= eff_pre_n;
            eff_post <= eff_post_n;
            cnt_pre  <= cnt_pre_n;
            cnt_post <= cnt_post_n;
            src_prev <= src_lvl;
            root_clk <= root_n;
        end
    end

endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice
    import clk_root_pkg::*;
#(
    parameter int NPAR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic [NPAR-1:0]   par_clk,
    output logic              root_clk,
    output logic              sel_err,
    output logic [PRE_W:0]    pre_ratio,
    output logic [POST_W:0]   post_ratio
);

    logic              req_en;
    logic [SEL_W-1:0]  req_sel;
    logic              req_sel_ok;
    logic [PRE_W-1:0]  req_pre;
    logic [POST_W-1:0] req_post;
    logic [NPAR-1:0]   par_sync;
    logic              src_lvl;
    logic [SEL_W-1:0]  eff_sel;
    logic [PRE_W-1:0]  eff_pre;
    logic [POST_W-1:0] eff_post;
    logic [PRE_W-1:0]  cnt_pre;
    logic [POST_W-1:0] cnt_post;
    logic              bnd;
    root_state_e       state;

    clk_root_regs #(.NPAR(NPAR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .en      (req_en),
        .sel     (req_sel),
        .sel_ok  (req_sel_ok),
        .pre     (req_pre),
        .post    (req_post)
    );

    clk_root_sync #(.NPAR(NPAR)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_clk  (par_clk),
        .par_sync (par_sync)
    );

    always_comb begin
        src_lvl = 1'b0;
        for (int i = 0; i < NPAR; i++) begin
            if (32'(eff_sel) == i) src_lvl = par_sync[i];
        end
    end

    clk_root_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (req_en),
        .req_sel    (req_sel),
        .req_sel_ok (req_sel_ok),
        .req_pre    (req_pre),
        .req_post   (req_post),
        .src_lvl    (src_lvl),
        .eff_sel    (eff_sel),
        .eff_pre    (eff_pre),
        .eff_post   (eff_post),
        .cnt_pre    (cnt_pre),
        .cnt_post   (cnt_post),
        .bnd        (bnd),
        .state      (state),
        .root_clk   (root_clk)
    );

    assign sel_err    = ~req_sel_ok;
    assign pre_ratio  = {1'b0, eff_pre} + (PRE_W+1)'(1);
    assign post_ratio = {1'b0, eff_post} + (POST_W+1)'(1);

endmodule

// File: rtl/clk_root_slice_chk.sv
module clk_root_slice_chk
    import clk_root_pkg::*;
#(
    parameter int NPAR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] rd_data,
    input logic              root_clk,
    input logic [SEL_W-1:0]  eff_sel,
    input logic [PRE_W-1:0]  eff_pre,
    input logic [PRE_W-1:0]  cnt_pre,
    input logic [PRE_W:0]    pre_ratio,
    input logic [POST_W:0]   post_ratio,
    input logic              bnd,
    input root_state_e       state
);

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & ctrl_mask()))); // R1

    AST_PRE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pre <= eff_pre); // R2

    AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |=> !root_clk); // R6

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(eff_sel) < NPAR); // R7

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !bnd) |=> ($stable(pre_ratio) && $stable(post_ratio))); // R8

endmodule

bind clk_root_slice clk_root_slice_chk #(.NPAR(NPAR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .root_clk   (root_clk),
    .eff_sel    (eff_sel),
    .eff_pre    (eff_pre),
    .cnt_pre    (cnt_pre),
    .pre_ratio  (pre_ratio),
    .post_ratio (post_ratio),
    .bnd        (bnd),
    .state      (state)
);

// File: tb/test_clk_root_slice.sv
`timescale 1ns/1ps
module test_clk_root_slice;

    localparam int NPAR = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NPAR-1:0] par_clk = '0;
    logic        root_clk;
    logic        sel_err;
    logic [3:0]  pre_ratio;
    logic [6:0]  post_ratio;

    int total = 0;
    int fails = 0;
    bit done = 0;
    int per [NPAR] = '{4, 6, 8, 10, 12, 14};

    always #2.5 clk = ~clk;

    clk_root_slice #(.NPAR(NPAR)) i_clk_root_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .par_clk    (par_clk),
        .root_clk   (root_clk),
        .sel_err    (sel_err),
        .pre_ratio  (pre_ratio),
        .post_ratio (post_ratio)
    );

    initial begin
        int cnt [NPAR];
        for (int i = 0; i < NPAR; i++) cnt[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < NPAR; i++) begin
                cnt[i] = (cnt[i] + 1) % per[i];
                par_clk[i] = (cnt[i] < per[i] / 2);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(bit en, int sel, int pre, int post);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = (32'(en) << 28) | (32'(sel) << 24) | (32'(pre) << 16) | 32'(post);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (root_clk) @(negedge clk);
        while (!root_clk) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        wait_rise();
        hi = 0;
        while (root_clk) begin hi++; @(negedge clk); end
        lo = 0;
        while (!root_clk) begin lo++; @(negedge clk); end
    endtask

    function automatic int exp_hi(int p, int a, int b);
        if (b >= 2) return (b / 2) * a * p;
        if (a >= 2) return (a / 2) * p;
        return p / 2;
    endfunction

    task automatic run_case(string req, int sel, int pre, int post);
        int hi, lo;
        int a, b;
        a = pre + 1;
        b = post + 1;
        cfg(1'b1, sel, pre, post);
        measure(hi, lo);
        check(req, hi + lo, per[sel] * a * b);
        check({req, "_R5"}, hi, exp_hi(per[sel], a, b));
        check("R9_pre", int'(pre_ratio), a);
        check("R9_post", int'(post_ratio), b);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int hi, lo, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1_reset", int'(rd_data), 0);
        check("R6_reset", int'(root_clk), 0);
        check("R9_reset_pre", int'(pre_ratio), 1);
        check("R9_reset_post", int'(post_ratio), 1);
        check("R7_reset", int'(sel_err), 0);

        cfg(1'b0, 0, 0, 0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R1_mask", int'(rd_data), int'(32'h1707_003F));
        check("R7_flag", int'(sel_err), 1);

        cfg(1'b0, 0, 0, 0);
        highs = 0;
        repeat (100) begin @(negedge clk); if (root_clk) highs++; end
        check("R6_disabled", highs, 0);

        for (int i = 0; i < NPAR; i++) run_case("R4_parent", i, 1, 2);
        for (int p = 0; p < 8; p++)
            for (int q = 0; q < 3; q++) run_case("R2_pre", 0, p, q);
        for (int q = 0; q < 64; q++) run_case("R3_post", 0, 0, q);

        run_case("R7_base", 1, 0, 1);
        cfg(1'b1, 6, 0, 1);
        check("R7_flag_run", int'(sel_err), 1);
        check("R1_sel_field", int'(rd_data[26:24]), 6);
        measure(hi, lo);
        check("R7_keep_parent", hi + lo, 12);
        cfg(1'b1, 0, 0, 1);
        check("R7_clear", int'(sel_err), 0);
        measure(hi, lo);
        check("R7_new_parent", hi + lo, 8);

        run_case("R4_max", 0, 7, 63);
        wait_rise();
        repeat (10) @(negedge clk);
        cfg(1'b1, 0, 0, 0);
        check("R8_hold_post", int'(post_ratio), 64);
        check("R8_hold_pre", int'(pre_ratio), 8);
        check("R8_still_high", int'(root_clk), 1);
        while (root_clk) @(negedge clk);
        lo = 0;
        while (!root_clk) begin lo++; @(negedge clk); end
        check("R8_full_low", lo, 1024);
        check("R8_load_post", int'(post_ratio), 1);
        check("R8_load_pre", int'(pre_ratio), 1);
        measure(hi, lo);
        check("R5_passthrough", hi, 2);
        check("R4_passthrough", hi + lo, 4);

        cfg(1'b0, 0, 0, 0);
        @(negedge clk);
        highs = 0;
        repeat (100) begin @(negedge clk); if (root_clk) highs++; end
        check("R6_gate_off", highs, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule